// File: doc/BRIEF.md
# Periodic Consumer-Key Report Generator

This block watches three active-high front-panel buttons (mute, volume up, volume down) and builds a short report for an interrupt-in endpoint on a fixed cadence. Each button level is first brought into the clock domain through a two-flop synchronizer. It then passes a debounce filter that samples on a slow shared strobe. A free-running down-counter marks the end of each report interval. When it expires, the filtered key states are captured together with the consumer-control usage code of the highest-priority pressed key. The report is then offered to the endpoint buffer with a valid/ready handshake.

With the default parameters and a 12 MHz clock, the interval is 384000 cycles (32 ms) and debounce samples are 12000 cycles (1 ms) apart. A report that the endpoint has not taken is replaced by the next one, so the buffer always sees the freshest key state. While the suspend input is high, no reports are produced and the interval counter is held at its start value.

Top module: `hid_key_reporter`

## Requirements
- R1: After reset, `rpt_valid` is 0, `rpt_mask` is 3'b000 and `rpt_code` is 16'h0000.
- R2: Reports are produced every `PERIOD_CYC` clock cycles. The first report appears `PERIOD_CYC` cycles after the first clock edge with reset released; the default of 384000 gives 32 ms at 12 MHz.
- R3: `rpt_mask` bit 0 reflects mute, bit 1 volume up and bit 2 volume down, with 1 meaning pressed. An input held low reads as released.
- R4: `rpt_code` is the usage code of the lowest-numbered pressed key in the mask: 16'hE209 for mute, 16'hE909 for volume up, 16'hEA09 for volume down. It is 16'h0000 when the mask is zero.
- R5: A key level is taken into the report only after `DB_SAMPLES` consecutive debounce samples, spaced `SAMPLE_CYC` cycles apart, agree on the new level. A pulse covering fewer samples never appears in any report.
- R6: While `rpt_valid` is 1 and `rpt_ready` is 0, the report stays valid and unchanged until the next interval expires. A cycle with both high clears `rpt_valid` on the following edge.
- R7: When an interval expires while a report is still pending, the pending report is replaced by the new key state and stays valid.
- R8: While `suspend` is 1, `rpt_valid` is 0 from the next cycle on and no report is produced. After `suspend` falls, the first report appears `PERIOD_CYC` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (12 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| suspend | input | 1 | Stops reporting and holds the interval counter |
| key_mute | input | 1 | Mute button, active high, asynchronous |
| key_vol_up | input | 1 | Volume-up button, active high, asynchronous |
| key_vol_dn | input | 1 | Volume-down button, active high, asynchronous |
| rpt_ready | input | 1 | Endpoint buffer takes the report |
| rpt_valid | output | 1 | A report is pending |
| rpt_mask | output | 3 | Pressed-key mask (bit 0 mute, bit 1 up, bit 2 down) |
| rpt_code | output | 16 | Usage code of the lowest-numbered pressed key |

## Verification
The hardest case to reach from the ports is the overwrite. The interval must expire while the endpoint withholds `rpt_ready` and the key state has changed in between. The bench holds ready low and switches from one pressed key to another. It then waits for the mask to change while valid stays high, which shows that the expiry replaced the pending report. Only after that does it raise ready and confirm that valid clears. The glitch case is reached by holding a key high for two sample spacings only, which is short of the filter depth.

// File: rtl/hid_rpt_pkg.sv
// Package: shared key indices and usage-code mapping for the key reporter.
// Assumes three keys; index order sets the code priority (lowest wins).
package hid_rpt_pkg;

    localparam int unsigned NUM_KEYS = 3;
    localparam int unsigned CODE_W   = 16;

    typedef enum logic [1:0] {
        KEY_MUTE = 2'd0,
        KEY_UP   = 2'd1,
        KEY_DOWN = 2'd2
    } key_idx_e;

    localparam logic [CODE_W-1:0] CODE_MUTE = 16'hE209;
    localparam logic [CODE_W-1:0] CODE_UP   = 16'hE909;
    localparam logic [CODE_W-1:0] CODE_DOWN = 16'hEA09;
    localparam logic [CODE_W-1:0] CODE_NONE = 16'h0000;

    typedef struct packed {
        logic [NUM_KEYS-1:0] mask;
        logic [CODE_W-1:0]   code;
    } report_t;

    // Priority encode: lowest pressed index selects the code.
    function automatic logic [CODE_W-1:0] code_of(input logic [NUM_KEYS-1:0] m);
        if (m[KEY_MUTE])      return CODE_MUTE;
        else if (m[KEY_UP])   return CODE_UP;
        else if (m[KEY_DOWN]) return CODE_DOWN;
        else                  return CODE_NONE;
    endfunction

endpackage

// File: rtl/interval_timer.sv
// Module: interval_timer
// Down-counter that pulses `done` once every LENGTH cycles. While `hold`
// is high the count is reloaded and `done` stays low, so the next pulse
// comes LENGTH cycles after hold falls. Assumes LENGTH >= 2.
module interval_timer #(
    parameter int unsigned LENGTH = 384000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic done
);
    localparam int unsigned CNT_W = (LENGTH > 1) ? $clog2(LENGTH) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LENGTH - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry when the count reaches zero outside hold.
    assign done = (cnt_q == '0) && !hold;

    // Count down, reload on expiry, hold or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || done) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/key_sync.sv
// Module: key_sync
// Two-flop synchronizer bringing an asynchronous button level into the
// clock domain. Resets to released (0).
module key_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    // Two-stage capture of the raw level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/key_debounce.sv
// Module: key_debounce
// Accepts a new level only after DB_SAMPLES consecutive strobed samples
// differ from the current filtered level. Any agreeing sample restarts
// the run. Assumes `sample` is a one-cycle strobe.
module key_debounce #(
    parameter int unsigned DB_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic level_in,
    output logic level_out
);
    localparam int unsigned RUN_W = (DB_SAMPLES > 1) ? $clog2(DB_SAMPLES) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DB_SAMPLES - 1);

    logic             stable_q;
    logic [RUN_W-1:0] run_q;

    // Count disagreeing samples; flip the filtered level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            run_q    <= '0;
        end else if (sample) begin
            if (level_in == stable_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                stable_q <= level_in;
                run_q    <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_out = stable_q;
endmodule

// File: rtl/report_slot.sv
// Module: report_slot
// Single-entry report holder. On `capture` it loads the mask and its
// code, replacing any pending report. The handshake empties it, and
// `flush` drops the content. Capture wins over the handshake.
module report_slot
    import hid_rpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                flush,
    input  logic [NUM_KEYS-1:0] keys,
    input  logic                ready,
    output logic                valid,
    output report_t             rpt
);
    logic    valid_q;
    report_t rpt_q;

    // Load, overwrite, hand over or drop the pending report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rpt_q   <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (capture) begin
            valid_q    <= 1'b1;
            rpt_q.mask <= keys;
            rpt_q.code <= code_of(keys);
        end else if (valid_q && ready) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign rpt   = rpt_q;
endmodule

// File: rtl/hid_key_reporter.sv
// Module: hid_key_reporter
// Top: synchronizes and debounces three buttons, then offers a report of
// the filtered state every PERIOD_CYC cycles to an endpoint buffer.
// Assumes one clock; key inputs are asynchronous; suspend is synchronous.
module hid_key_reporter
    import hid_rpt_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 384000,
    parameter int unsigned SAMPLE_CYC = 12000,
    parameter int unsigned DB_SAMPLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        suspend,
    input  logic        key_mute,
    input  logic        key_vol_up,
    input  logic        key_vol_dn,
    input  logic        rpt_ready,
    output logic        rpt_valid,
    output logic [2:0]  rpt_mask,
    output logic [15:0] rpt_code
);
    logic [NUM_KEYS-1:0] key_raw;
    logic [NUM_KEYS-1:0] key_synced;
    logic [NUM_KEYS-1:0] key_stable;
    logic                sample_tick;
    logic                period_done;
    report_t             slot_rpt;

    assign key_raw[KEY_MUTE] = key_mute;
    assign key_raw[KEY_UP]   = key_vol_up;
    assign key_raw[KEY_DOWN] = key_vol_dn;

    // Debounce sampling strobe, free running.
    interval_timer #(.LENGTH(SAMPLE_CYC)) u_sample_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (1'b0),
        .done  (sample_tick)
    );

    // Report interval, held in its start state during suspend.
    interval_timer #(.LENGTH(PERIOD_CYC)) u_period_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (suspend),
        .done  (period_done)
    );

    // Per-key input conditioning.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        key_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (key_raw[k]),
            .sync_out (key_synced[k])
        );
        key_debounce #(.DB_SAMPLES(DB_SAMPLES)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample    (sample_tick),
            .level_in  (key_synced[k]),
            .level_out (key_stable[k])
        );
    end

    report_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (period_done),
        .flush   (suspend),
        .keys    (key_stable),
        .ready   (rpt_ready),
        .valid   (rpt_valid),
        .rpt     (slot_rpt)
    );

    assign rpt_mask = slot_rpt.mask;
    assign rpt_code = slot_rpt.code;
endmodule

// File: rtl/hid_key_reporter_chk.sv
// Module: hid_key_reporter_chk
// Property checker bound to hid_key_reporter. Observes ports and the
// internal strobes; drives nothing.
module hid_key_reporter_chk #(
    parameter int unsigned PERIOD_CYC = 384000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        suspend,
    input logic        rpt_ready,
    input logic        rpt_valid,
    input logic [2:0]  rpt_mask,
    input logic [15:0] rpt_code,
    input logic        period_done,
    input logic        sample_tick,
    input logic [2:0]  key_stable
);
    localparam int unsigned GAP_W = $clog2(PERIOD_CYC) + 1;
    logic [GAP_W-1:0] gap_q;

    // Cycles since reset, suspend or the last expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || suspend || period_done) gap_q <= '0;
        else                                  gap_q <= gap_q + 1'b1;
    end

    // R2: expiry only after a full interval
    a_r2_period_len: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |-> gap_q == GAP_W'(PERIOD_CYC - 1));

    // R4: code agrees with the mask
    a_r4_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> ((rpt_mask == 3'b000) == (rpt_code == 16'h0000)) &&
                      (!rpt_mask[0] || rpt_code == 16'hE209));

    // R5: filtered levels move only on a sample strobe
    a_r5_filter_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_stable) |-> $past(sample_tick));

    // R6: a pending report is held while not taken
    a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready && !period_done && !suspend) |=>
            rpt_valid && $stable(rpt_mask) && $stable(rpt_code));

    // R6: handshake empties the slot
    a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_ready && !period_done) |=> !rpt_valid);

    // R7: expiry always leaves a valid report
    a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> rpt_valid);

    // R8: suspend silences reporting
    a_r8_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> !rpt_valid);
endmodule

bind hid_key_reporter hid_key_reporter_chk #(.PERIOD_CYC(PERIOD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .suspend     (suspend),
    .rpt_ready   (rpt_ready),
    .rpt_valid   (rpt_valid),
    .rpt_mask    (rpt_mask),
    .rpt_code    (rpt_code),
    .period_done (period_done),
    .sample_tick (sample_tick),
    .key_stable  (key_stable)
);

// File: tb/hid_key_reporter_bench.sv
module hid_key_reporter_bench;
    localparam int P  = 64;
    localparam int SC = 4;
    localparam int DB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic suspend = 1'b0;
    logic key_mute = 1'b0, key_vol_up = 1'b0, key_vol_dn = 1'b0;
    logic rpt_ready = 1'b1;
    logic rpt_valid;
    logic [2:0] rpt_mask;
    logic [15:0] rpt_code;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hid_key_reporter #(.PERIOD_CYC(P), .SAMPLE_CYC(SC), .DB_SAMPLES(DB)) u_hid_key_reporter (
        .clk(clk), .rst_n(rst_n), .suspend(suspend),
        .key_mute(key_mute), .key_vol_up(key_vol_up), .key_vol_dn(key_vol_dn),
        .rpt_ready(rpt_ready), .rpt_valid(rpt_valid),
        .rpt_mask(rpt_mask), .rpt_code(rpt_code)
    );

    function automatic logic [15:0] exp_code(input logic [2:0] m);
        logic [15:0] c;
        c = 16'h0000;
        if (m[2]) c = 16'hEA09;
        if (m[1]) c = 16'hE909;
        if (m[0]) c = 16'hE209;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_keys(input logic [2:0] m);
        key_mute = m[0]; key_vol_up = m[1]; key_vol_dn = m[2];
    endtask

    // Count negedges until valid is seen; returns count.
    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rpt_valid && n < 4 * P);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    initial begin
        int n;
        logic [2:0] m;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rpt_valid == 1'b0 && rpt_mask == 3'b000 && rpt_code == 16'h0,
              "R1", {rpt_valid, rpt_mask, rpt_code}, 0);
        rst_n = 1'b1;
        wait_valid(n);
        check(n == P, "R2 first report", n, P);
        check(rpt_mask == 3'b000 && rpt_code == 16'h0, "R3 idle mask", rpt_mask, 0);
        wait_valid(n);
        check(n == P, "R2 interval", n, P);

        // R3/R4 exhaustive sweep over all key patterns
        for (int p = 0; p < 8; p++) begin
            m = 3'(p);
            set_keys(m);
            repeat (2 * P) @(negedge clk);
            wait_valid(n);
            check(rpt_mask == m, "R3 mask", rpt_mask, m);
            check(rpt_code == exp_code(m), "R4 code", rpt_code, exp_code(m));
        end
        set_keys(3'b000);
        repeat (2 * P) @(negedge clk);

        // R5 short pulse (2 sample spacings) must never show up
        key_vol_up = 1'b1;
        repeat (2 * SC) @(negedge clk);
        key_vol_up = 1'b0;
        for (int r = 0; r < 3; r++) begin
            wait_valid(n);
            check(rpt_mask == 3'b000, "R5 glitch filtered", rpt_mask, 0);
        end

        // R6/R7 hold and overwrite with ready withheld
        rpt_ready = 1'b0;
        set_keys(3'b001);
        repeat (2 * P) @(negedge clk);
        check(rpt_valid && rpt_mask == 3'b001, "R6 pending held", {rpt_valid, rpt_mask}, 4'b1001);
        set_keys(3'b100);
        n = 0;
        while (rpt_mask != 3'b100 && n < 4 * P) begin
            @(negedge clk);
            n++;
            if (!rpt_valid) break;
        end
        check(rpt_valid == 1'b1, "R7 still valid", rpt_valid, 1);
        check(rpt_mask == 3'b100 && rpt_code == 16'hEA09, "R7 overwritten", rpt_code, 16'hEA09);
        repeat (5) @(negedge clk);
        check(rpt_valid && rpt_code == 16'hEA09, "R6 stable", rpt_code, 16'hEA09);
        rpt_ready = 1'b1;
        @(negedge clk);
        check(rpt_valid == 1'b0, "R6 take clears", rpt_valid, 0);

        // R8 suspend
        suspend = 1'b1;
        @(negedge clk);
        check(rpt_valid == 1'b0, "R8 cleared", rpt_valid, 0);
        n = 0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (rpt_valid) n++;
        end
        check(n == 0, "R8 no reports", n, 0);
        suspend = 1'b0;
        wait_valid(n);
        check(n == P, "R8 restart", n, P);
        check(rpt_mask == 3'b100, "R8 resumed mask", rpt_mask, 3'b100);
        finish_run();
    end
endmodule